// File: doc/BRIEF.md
# Thermometer-to-Binary Flash Encoder

This block sits behind the comparator bank of a 4-bit flash converter. It receives the 15 comparator decisions as a thermometer word and returns a 4-bit binary code. All comparator bits are registered together on one sampling-clock edge, so the rest of the block works on a word that is coherent in time.

Before encoding, the captured word passes through a bubble filter. Each bit is replaced by the 3-input majority of itself and its two neighbours. Below the lowest level the missing neighbour is taken as 1, and above the highest level it is taken as 0. This filter clears a lone high bit and fills a lone low hole.

The cleaned word is first turned into a Gray code. Each Gray bit is the XOR of the levels that are odd multiples of its weight. The Gray code is then turned into binary by a chain of XOR gates that runs from the most significant bit down. The result is registered and flagged valid. A new word can be accepted on every clock, and each result appears two clocks after its word was applied.

Top module: `therm_flash_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, and on the first edge after it falls, `code_out` reads 0 and `code_valid` reads 0.
- R2: `code_valid` goes high on the second rising edge after `rst` falls and stays high until the next reset.
- R3: A word present on `cmp_in` at rising edge n is reflected on `code_out` after rising edge n+1, and a new word is accepted on every edge.
- R4: Input bit i (i = 0 for the lowest level) is 1 when the analog input is at or above level i+1. A thermometer word whose k lowest bits are 1 and whose other bits are 0 encodes to the binary value k.
- R5: An all-zero word encodes to 0000 and an all-ones word encodes to 1111.
- R6: A 1 bit whose neighbours on both sides are 0 is cleared before encoding. Below bit 0 the neighbour counts as 1, and above bit 14 it counts as 0.
- R7: A 0 bit whose neighbours on both sides are 1 is set before encoding, under the same boundary rule as R6.
- R8: The most significant output bit equals the cleaned value of the midpoint level, which is input bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 15 | Comparator decisions; bit 0 is the lowest reference level |
| code_out | output | 4 | Registered binary code |
| code_valid | output | 1 | High when `code_out` holds a result of a sampled word |

## Verification
All sixteen proper thermometer words are stepped through in both rising and falling order. These runs confirm that each level count maps to its own code, and that the midpoint bit alone drives the top output bit. Words with one flipped bit are then applied at the bottom, the top and the middle of the scale. Two kinds of flip are used: a lone 1 above the run and a lone 0 inside it. These runs separate the clearing of isolated highs from the filling of holes, including the two edge cases that use the constant boundary neighbours. Finally, a fast alternation between distant codes shows that each word emerges exactly two edges after it is applied and that back-to-back words do not blend.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

    // Default resolution of the converter this encoder serves.
    localparam int ADC_BITS   = 4;
    localparam int ADC_LEVELS = (1 << ADC_BITS) - 1;
    localparam int PIPE_DEPTH = 2;

    // Majority of three, used by the bubble filter.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // True when the lowest n bits of w form a run of ones followed by zeros.
    function automatic logic is_thermo(input logic [63:0] w, input int n);
        logic seen_zero;
        seen_zero = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (!w[i])
                seen_zero = 1'b1;
            else if (seen_zero)
                return 1'b0;
        end
        return 1'b1;
    endfunction

    // Decides whether level k (1-based) feeds Gray bit j.
    function automatic logic feeds_gray(input int k, input int j);
        return (k % (1 << (j + 1))) == (1 << j);
    endfunction

endpackage

// File: rtl/tfe_sample_reg.sv
module tfe_sample_reg #(
    parameter int WIDTH = tfe_pkg::ADC_LEVELS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             live
);

    // Every comparator bit is taken on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            live <= 1'b0;
        end else begin
            q    <= d;
            live <= 1'b1;
        end
    end

endmodule

// File: rtl/tfe_bubble_filter.sv
module tfe_bubble_filter #(
    parameter int WIDTH = tfe_pkg::ADC_LEVELS
) (
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] clean
);

    // Padded word: a 1 sits below the lowest level and a 0 above the highest.
    logic [WIDTH+1:0] padded;
    assign padded = {1'b0, raw, 1'b1};

    for (genvar k = 0; k < WIDTH; k++) begin : g_vote
        assign clean[k] = tfe_pkg::maj3(padded[k], padded[k+1], padded[k+2]);
    end

endmodule

// File: rtl/tfe_gray_encode.sv
module tfe_gray_encode #(
    parameter  int NBITS = tfe_pkg::ADC_BITS,
    localparam int NLVL  = (1 << NBITS) - 1
) (
    input  logic [NLVL-1:0]  therm,
    output logic [NBITS-1:0] gray
);

    // Each Gray bit is the XOR of the levels that are odd multiples of its weight.
    for (genvar j = 0; j < NBITS; j++) begin : g_bit
        always_comb begin
            gray[j] = 1'b0;
            for (int k = 1; k <= NLVL; k++) begin
                if (tfe_pkg::feeds_gray(k, j))
                    gray[j] = gray[j] ^ therm[k-1];
            end
        end
    end

endmodule

// File: rtl/tfe_gray_to_bin.sv
module tfe_gray_to_bin #(
    parameter int NBITS = tfe_pkg::ADC_BITS
) (
    input  logic [NBITS-1:0] gray,
    output logic [NBITS-1:0] bin
);

    assign bin[NBITS-1] = gray[NBITS-1];

    // The XOR chain runs from the top bit downwards.
    for (genvar j = NBITS - 2; j >= 0; j--) begin : g_chain
        assign bin[j] = bin[j+1] ^ gray[j];
    end

endmodule

// File: rtl/therm_flash_encoder.sv
module therm_flash_encoder #(
    parameter  int NBITS = tfe_pkg::ADC_BITS,
    localparam int NLVL  = (1 << NBITS) - 1,
    localparam int MID   = (1 << (NBITS - 1)) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NLVL-1:0]  cmp_in,
    output logic [NBITS-1:0] code_out,
    output logic             code_valid
);

    logic [NLVL-1:0]  sampled;
    logic             sampled_live;
    logic [NLVL-1:0]  cleaned;
    logic [NBITS-1:0] gray_w;
    logic [NBITS-1:0] bin_w;

    tfe_sample_reg #(.WIDTH(NLVL)) u_sample (
        .clk  (clk),
        .rst  (rst),
        .d    (cmp_in),
        .q    (sampled),
        .live (sampled_live)
    );

    tfe_bubble_filter #(.WIDTH(NLVL)) u_filter (
        .raw   (sampled),
        .clean (cleaned)
    );

    tfe_gray_encode #(.NBITS(NBITS)) u_gray (
        .therm (cleaned),
        .gray  (gray_w)
    );

    tfe_gray_to_bin #(.NBITS(NBITS)) u_bin (
        .gray (gray_w),
        .bin  (bin_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_out   <= '0;
            code_valid <= 1'b0;
        end else begin
            code_out   <= bin_w;
            code_valid <= sampled_live;
        end
    end

    // R1: reset clears the output stage
    p_reset_clears_r1: assert property (@(posedge clk)
        $past(rst) |-> (code_out == '0 && !code_valid));

    // R2: once valid, stays valid until reset
    p_valid_holds_r2: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> code_valid);

    // R6/R7: a word that is already a thermometer code passes the filter unchanged
    p_filter_transparent_r6: assert property (@(posedge clk) disable iff (rst)
        tfe_pkg::is_thermo(64'(sampled), NLVL) |-> (cleaned == sampled));

    // R8: the top output bit follows the cleaned midpoint level
    p_msb_midpoint_r8: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> (code_out[NBITS-1] == $past(cleaned[MID])));

    // R5: a full-scale sample gives the maximum code
    p_full_scale_r5: assert property (@(posedge clk) disable iff (rst)
        (code_valid && $past(&sampled)) |-> (&code_out));

    // R5: an empty sample gives code zero
    p_zero_scale_r5: assert property (@(posedge clk) disable iff (rst)
        (code_valid && $past(sampled == '0)) |-> (code_out == '0));

endmodule

// File: tb/therm_flash_encoder_test.sv
module therm_flash_encoder_test;

    localparam int NB = 4;
    localparam int NL = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] cmp_in = '0;
    logic [NB-1:0] code_out;
    logic          code_valid;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    therm_flash_encoder uut (
        .clk        (clk),
        .rst        (rst),
        .cmp_in     (cmp_in),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

    // Behavioural reference: vote each bit, then count the ones that remain.
    function automatic int ref_value(input logic [NL-1:0] w);
        int n;
        int below;
        int above;
        int votes;
        n = 0;
        for (int i = 0; i < NL; i++) begin
            below = (i == 0) ? 1 : int'(w[i-1]);
            above = (i == NL - 1) ? 0 : int'(w[i+1]);
            votes = below + above + int'(w[i]);
            if (votes >= 2) n++;
        end
        return n;
    endfunction

    function automatic logic [NL-1:0] thermo(input int k);
        logic [NL-1:0] w;
        w = '0;
        for (int i = 0; i < k; i++) w[i] = 1'b1;
        return w;
    endfunction

    // Cycle model: stage one holds the sampled value, stage two the result.
    int m_stage1 = 0;
    int m_live1  = 0;
    int m_code   = 0;
    int m_valid  = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_stage1 <= 0;
            m_live1  <= 0;
            m_code   <= 0;
            m_valid  <= 0;
        end else begin
            m_stage1 <= ref_value(cmp_in);
            m_live1  <= 1;
            m_code   <= m_stage1;
            m_valid  <= m_live1;
        end
    end

    task automatic check_now();
        checks++;
        if (int'(code_out) != m_code || int'(code_valid) != m_valid) begin
            errors++;
            $display("FAIL %s: code=%0d valid=%0d expected code=%0d valid=%0d",
                     phase, code_out, code_valid, m_code, m_valid);
        end
        if (m_valid == 1) begin
            checks++;
            if (code_out[NB-1] != (m_code >= 8)) begin
                errors++;
                $display("FAIL R8: msb=%0d expected %0d", code_out[NB-1], m_code >= 8);
            end
        end
    endtask

    // Compare on the falling edge, then present the next word.
    task automatic step(input logic [NL-1:0] w);
        @(negedge clk);
        check_now();
        cmp_in = w;
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        cmp_in = thermo(9);
        repeat (3) step(thermo(9));
        @(negedge clk);
        rst = 1'b0;
        // R2: valid rises on the second edge after release
        phase = "R2";
        @(negedge clk);
        checks++;
        if (code_valid !== 1'b0 || code_out !== '0) begin
            errors++;
            $display("FAIL R1: after first edge code=%0d valid=%0d expected 0 0", code_out, code_valid);
        end
        @(negedge clk);
        checks++;
        if (code_valid !== 1'b1 || code_out !== 4'd9) begin
            errors++;
            $display("FAIL R2: after second edge code=%0d valid=%0d expected 9 1", code_out, code_valid);
        end
        // R4 / R5: every proper code, ascending then descending
        phase = "R4";
        for (int k = 0; k <= NL; k++) step(thermo(k));
        for (int k = NL; k >= 0; k--) step(thermo(k));
        phase = "R5";
        step('0); step('0); step('1); step('1); step('1);
        // R6: lone high bit above the run, including both ends of the scale
        phase = "R6";
        step(15'h0004);
        step(15'h0002); step(15'h0002);
        step(15'h4000); step(15'h4000);
        for (int k = 0; k <= NL - 3; k++) begin
            step(thermo(k) | (15'(1) << (k + 1)));
            step(thermo(k) | (15'(1) << (k + 1)));
        end
        // R7: lone hole inside the run, including the bottom level
        phase = "R7";
        step(15'h7FFE); step(15'h7FFE);
        for (int k = 3; k <= NL; k++) begin
            step(thermo(k) & ~(15'(1) << (k - 2)));
            step(thermo(k) & ~(15'(1) << (k - 2)));
        end
        // R3: back-to-back distant words must not blend
        phase = "R3";
        for (int r = 0; r < 6; r++) begin
            step(thermo(1)); step(thermo(14)); step(thermo(7)); step(thermo(8));
        end
        step('0); step('0); step('0);
        // R2: reset again, valid drops
        phase = "R1";
        rst = 1'b1;
        step('1); step('1);
        rst = 1'b0;
        phase = "R2";
        step('1); step('1); step('1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule